// File: doc/BRIEF.md
# Audio codec input frame serializer

This block is the codec-side transmitter of a framed, time-slotted serial audio link. It runs on the link bit clock and watches a frame sync line that the controller changes on a rising edge. When it sees sync go from low to high, it builds one 256-bit input frame and shifts it out on a single serial data line, most significant bit first, one bit per bit clock. The frame is a 16-bit tag slot followed by twelve 20-bit slots: a status address slot, a status data slot and ten audio data slots.

The tag slot carries a global ready flag and one valid flag per slot. Every bit position that is not valid is driven as zero. This covers invalid slots, the reserved tail of the tag and every slot while the codec is not ready. The status address slot returns the 7-bit register index being answered, along with 10 variable-rate request bits. All payloads and flags are captured when the frame starts, so the upstream logic may change them while a frame is on the line.

Top module: `afs_frame_tx`

## Requirements
- R1: After reset and between frames, `sdataOut` is held at 0.
- R2: A frame starts on the first rising clock edge at which `syncIn` is sampled high after being sampled low at the previous rising edge. The first frame bit appears on `sdataOut` right after that edge.
- R3: The frame is 256 bits long and is sent MSB first, one bit per clock. After the last bit, `sdataOut` returns to 0.
- R4: Tag slot (frame bits 15..0 of the first 16 transmitted): bit 15 is the ready flag. Bit 14 down to bit 3 are the valid flags of slots 1 to 12 in that order, with bit 14 for slot 1. Bits 2..0 are 0.
- R5: While `codecReady` is low at frame start, every slot valid flag and every slot payload bit is sent as 0, so the whole frame is 0.
- R6: A slot whose valid flag (`slotValid[s-1]` for slot s) is low is sent as twenty 0 bits, and its tag bit is 0.
- R7: Slot 1 (bits 19..0): bit 19 is 0, bits 18:12 carry `regIndex`, bits 11:2 carry `rateReq`, bits 1:0 are 0.
- R8: Slot 2 carries `statusData`. Slot s for s = 3..12 carries `audioData[(s-3)*20 +: 20]`. Slot s starts 16 + 20*(s-1) bits after the frame's first bit.
- R9: Inputs are captured at frame start. Changes to them during a frame do not alter that frame.
- R10: A new sync rise during a frame aborts it and starts a new frame with freshly captured inputs.
- R11: Sync held high past the end of a frame does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Frame sync from the controller |
| codecReady | input | 1 | Global ready flag for the tag slot |
| slotValid | input | 12 | Valid flag per slot, bit s-1 for slot s |
| regIndex | input | 7 | Register index echoed in slot 1 |
| rateReq | input | 10 | Variable-rate request bits for slot 1 |
| statusData | input | 20 | Status data payload for slot 2 |
| audioData | input | 200 | Audio payloads for slots 3..12, 20 bits each, slot 3 lowest |
| sdataOut | output | 1 | Serial frame data, MSB first |

## Verification
On every cycle, the assertions check the sync-edge start, the bit counter's one-per-clock advance, the return to idle after the last bit, the capture of the assembled frame into the shift register, the single-position shift, and the ready flag appearing as the first bit. Only the bench scenarios can show that the tag, slot 1 layout, slot ordering and zero stuffing are right over whole frames. The same holds for input capture surviving mid-frame changes, restart on a new sync rise, and no retrigger while sync stays high.

// File: rtl/afs_pkg.sv
package afs_pkg;
  // Strobes from the frame sequencer to the shift datapath
  typedef struct packed {
    logic load;   // capture the assembled frame
    logic shift;  // advance one bit position
    logic drive;  // a frame bit is on the line
  } shiftCtrl_t;
endpackage

// File: rtl/afs_ctrl.sv
module afs_ctrl
  import afs_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  output shiftCtrl_t strobes
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic             syncPrev;
  logic             active;
  logic [CNT_W-1:0] bitCnt;
  logic             syncRise;

  assign syncRise = syncIn & ~syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      active   <= 1'b0;
      bitCnt   <= '0;
    end else begin
      syncPrev <= syncIn;
      if (syncRise) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (active) begin
        if (bitCnt == LAST_POS) begin
          active <= 1'b0;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.load  = syncRise;
    strobes.shift = active & ~syncRise & (bitCnt != LAST_POS);
    strobes.drive = active;
  end

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncIn) |=> (active && bitCnt == '0)); // R2
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (active && bitCnt != LAST_POS && !$rose(syncIn)) |=> (active && bitCnt == $past(bitCnt) + 1'b1)); // R3
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (active && bitCnt == LAST_POS && !$rose(syncIn)) |=> !active); // R3
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (!active && syncIn && $past(syncIn)) |=> !active); // R11
endmodule

// File: rtl/afs_frame_build.sv
module afs_frame_build #(
  parameter int SLOT_COUNT = 12,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int IDX_BITS   = 7,
  parameter int REQ_BITS   = 10,
  localparam int FRAME_BITS = TAG_BITS + SLOT_COUNT * SLOT_BITS,
  localparam int AUDIO_W    = (SLOT_COUNT - 2) * SLOT_BITS
) (
  input  logic                  codecReady,
  input  logic [SLOT_COUNT-1:0] slotValid,
  input  logic [IDX_BITS-1:0]   regIndex,
  input  logic [REQ_BITS-1:0]   rateReq,
  input  logic [SLOT_BITS-1:0]  statusData,
  input  logic [AUDIO_W-1:0]    audioData,
  output logic [FRAME_BITS-1:0] frameOut
);
  localparam int RSV_BITS = TAG_BITS - 1 - SLOT_COUNT;
  localparam int PAD_LO   = SLOT_BITS - 1 - IDX_BITS - REQ_BITS;

  logic [SLOT_COUNT-1:0] effValid;
  logic [TAG_BITS-1:0]   tagWord;
  logic [SLOT_BITS-1:0]  rawSlot [SLOT_COUNT];

  // Valid flags only count while the codec reports ready
  assign effValid = slotValid & {SLOT_COUNT{codecReady}};

  assign tagWord[TAG_BITS-1] = codecReady;
  for (genvar j = 0; j < SLOT_COUNT; j++) begin : g_tag
    assign tagWord[TAG_BITS-2-j] = effValid[j];
  end
  if (RSV_BITS > 0) begin : g_rsv
    assign tagWord[RSV_BITS-1:0] = '0;
  end

  if (PAD_LO > 0) begin : g_addrPad
    assign rawSlot[0] = {1'b0, regIndex, rateReq, {PAD_LO{1'b0}}};
  end else begin : g_addrNoPad
    assign rawSlot[0] = {1'b0, regIndex, rateReq};
  end
  assign rawSlot[1] = statusData;
  for (genvar a = 0; a < SLOT_COUNT - 2; a++) begin : g_audio
    assign rawSlot[a+2] = audioData[a*SLOT_BITS +: SLOT_BITS];
  end

  assign frameOut[FRAME_BITS-1 -: TAG_BITS] = tagWord;
  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_place
    assign frameOut[FRAME_BITS-TAG_BITS-s*SLOT_BITS-1 -: SLOT_BITS] =
      effValid[s] ? rawSlot[s] : '0;
  end

  always_comb begin
    if (!codecReady) begin
      AST_NOT_READY_EMPTY: assert (frameOut == '0); // R5
    end
  end
endmodule

// File: rtl/afs_shifter.sv
module afs_shifter
  import afs_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  shiftCtrl_t            strobes,
  input  logic [FRAME_BITS-1:0] frameIn,
  output logic                  sdataOut
);
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.load) begin
      shiftReg <= frameIn;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdataOut = strobes.drive & shiftReg[FRAME_BITS-1];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (shiftReg == $past(frameIn))); // R9
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> (shiftReg[FRAME_BITS-1] == $past(shiftReg[FRAME_BITS-2]))); // R3
endmodule

// File: rtl/afs_frame_tx.sv
module afs_frame_tx
  import afs_pkg::*;
#(
  parameter int SLOT_COUNT = 12,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int IDX_BITS   = 7,
  parameter int REQ_BITS   = 10,
  localparam int FRAME_BITS = TAG_BITS + SLOT_COUNT * SLOT_BITS,
  localparam int AUDIO_W    = (SLOT_COUNT - 2) * SLOT_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  syncIn,
  input  logic                  codecReady,
  input  logic [SLOT_COUNT-1:0] slotValid,
  input  logic [IDX_BITS-1:0]   regIndex,
  input  logic [REQ_BITS-1:0]   rateReq,
  input  logic [SLOT_BITS-1:0]  statusData,
  input  logic [AUDIO_W-1:0]    audioData,
  output logic                  sdataOut
);
  shiftCtrl_t            strobes;
  logic [FRAME_BITS-1:0] frameWord;

  afs_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .strobes (strobes)
  );

  afs_frame_build #(
    .SLOT_COUNT (SLOT_COUNT),
    .TAG_BITS   (TAG_BITS),
    .SLOT_BITS  (SLOT_BITS),
    .IDX_BITS   (IDX_BITS),
    .REQ_BITS   (REQ_BITS)
  ) u_build (
    .codecReady (codecReady),
    .slotValid  (slotValid),
    .regIndex   (regIndex),
    .rateReq    (rateReq),
    .statusData (statusData),
    .audioData  (audioData),
    .frameOut   (frameWord)
  );

  afs_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .frameIn  (frameWord),
    .sdataOut (sdataOut)
  );

  AST_READY_FIRST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncIn) |=> (sdataOut == $past(codecReady))); // R4
  AST_NOT_READY_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncIn) && !codecReady) |=> !sdataOut); // R5
endmodule

// File: tb/afs_frame_tx_tb.sv
module afs_frame_tx_tb;
  localparam int FB = 256;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         syncIn = 1'b0;
  logic         codecReady = 1'b0;
  logic [11:0]  slotValid = '0;
  logic [6:0]   regIndex = '0;
  logic [9:0]   rateReq = '0;
  logic [19:0]  statusData = '0;
  logic [199:0] audioData = '0;
  logic         sdataOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  afs_frame_tx u_dut (
    .clk (clk), .rstN (rstN), .syncIn (syncIn), .codecReady (codecReady),
    .slotValid (slotValid), .regIndex (regIndex), .rateReq (rateReq),
    .statusData (statusData), .audioData (audioData), .sdataOut (sdataOut)
  );

  function automatic logic [FB-1:0] expFrame(
    input logic rdy, input logic [11:0] v, input logic [6:0] idx,
    input logic [9:0] req, input logic [19:0] st, input logic [199:0] au);
    logic [FB-1:0] f;
    logic [19:0]   w;
    f = '0;
    if (rdy) begin
      f[255] = 1'b1;
      for (int s = 1; s <= 12; s++) begin
        if (v[s-1]) begin
          f[255 - s] = 1'b1;
          if (s == 1)      w = {1'b0, idx, req, 2'b00};
          else if (s == 2) w = st;
          else             w = au[(s-3)*20 +: 20];
          f[239 - 20*(s-1) -: 20] = w;
        end
      end
    end
    return f;
  endfunction

  task automatic chk(input string req, input logic [FB-1:0] got, input logic [FB-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic setInputs(input logic rdy, input logic [11:0] v, input int seed);
    codecReady = rdy;
    slotValid  = v;
    regIndex   = 7'(seed * 13 + 5);
    rateReq    = 10'(seed * 97 + 301);
    statusData = 20'(seed * 40503 + 12345);
    for (int a = 0; a < 10; a++)
      audioData[a*20 +: 20] = 20'((seed + 1) * 65537 * (a + 3) ^ (a * 4111));
  endtask

  // Raise sync at a falling edge; the next rising edge starts the frame
  task automatic raiseSync();
    @(negedge clk);
    syncIn = 1'b1;
  endtask

  // Collect n bits, one per falling edge; optionally drop sync after the first
  task automatic collect(input int n, input logic dropSync, output logic [FB-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[FB-1-i] = sdataOut;
      if (i == 0 && dropSync) syncIn = 1'b0;
    end
  endtask

  task automatic idleCheck(input string req, input int cycles);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      seen = seen | sdataOut;
    end
    chk(req, FB'(seen), '0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reset idle", FB'(sdataOut), '0);
    idleCheck("R1 idle before any sync", 8);
  endtask

  task automatic testFullFrame();
    logic [FB-1:0] got, exp;
    setInputs(1'b1, 12'hFFF, 1);
    exp = expFrame(1'b1, 12'hFFF, regIndex, rateReq, statusData, audioData);
    raiseSync();
    collect(FB, 1'b1, got);
    chk("R2 R3 full frame", got, exp);
    chk("R4 tag slot", FB'(got[255:240]), FB'(16'hFFF8));
    chk("R7 slot1 layout", FB'(got[239:220]), FB'({1'b0, regIndex, rateReq, 2'b00}));
    chk("R8 slot2 status", FB'(got[219:200]), FB'(statusData));
    chk("R8 slot3 audio0", FB'(got[199:180]), FB'(audioData[19:0]));
    chk("R8 slot12 audio9", FB'(got[19:0]), FB'(audioData[199:180]));
    idleCheck("R3 R1 line low after frame", 6);
  endtask

  task automatic testMixedValid();
    logic [FB-1:0] got, exp;
    setInputs(1'b1, 12'b1010_0110_0101, 2);
    exp = expFrame(1'b1, slotValid, regIndex, rateReq, statusData, audioData);
    raiseSync();
    collect(FB, 1'b1, got);
    chk("R6 mixed valid frame", got, exp);
    chk("R6 R4 tag mixed", FB'(got[255:240]), FB'({1'b1, 12'b1010_0110_0101, 3'b000}));
    chk("R6 invalid slot2 zero", FB'(got[219:200]), '0);
    idleCheck("R1 between frames", 4);
  endtask

  task automatic testNotReady();
    logic [FB-1:0] got;
    setInputs(1'b0, 12'hFFF, 3);
    raiseSync();
    collect(FB, 1'b1, got);
    chk("R5 not ready frame zero", got, '0);
    idleCheck("R1 after not-ready frame", 4);
  endtask

  task automatic testLatch();
    logic [FB-1:0] got, exp;
    setInputs(1'b1, 12'hFFF, 4);
    exp = expFrame(1'b1, 12'hFFF, regIndex, rateReq, statusData, audioData);
    raiseSync();
    @(negedge clk);
    got = '0;
    got[FB-1] = sdataOut;
    syncIn = 1'b0;
    setInputs(1'b0, 12'h000, 9);
    for (int i = 1; i < FB; i++) begin
      @(negedge clk);
      got[FB-1-i] = sdataOut;
    end
    chk("R9 inputs captured at start", got, exp);
    idleCheck("R1 after latch frame", 4);
  endtask

  task automatic testRestart();
    logic [FB-1:0] got, expA, expB;
    setInputs(1'b1, 12'hFFF, 5);
    expA = expFrame(1'b1, 12'hFFF, regIndex, rateReq, statusData, audioData);
    raiseSync();
    collect(100, 1'b1, got);
    chk("R10 partial first frame", FB'(got[255:156]), FB'(expA[255:156]));
    setInputs(1'b1, 12'b0111_1000_0011, 6);
    expB = expFrame(1'b1, slotValid, regIndex, rateReq, statusData, audioData);
    syncIn = 1'b1;
    collect(FB, 1'b1, got);
    chk("R10 restarted frame", got, expB);
    idleCheck("R1 after restart", 4);
  endtask

  task automatic testSyncHeld();
    logic [FB-1:0] got, exp;
    setInputs(1'b1, 12'hFFF, 7);
    exp = expFrame(1'b1, 12'hFFF, regIndex, rateReq, statusData, audioData);
    raiseSync();
    collect(FB, 1'b0, got);
    chk("R11 frame with sync held", got, exp);
    idleCheck("R11 no retrigger while high", 40);
    syncIn = 1'b0;
    idleCheck("R1 after sync release", 4);
  endtask

  initial begin
    fork
      begin
        #(5ns * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullFrame();
    testMixedValid();
    testNotReady();
    testLatch();
    testRestart();
    testSyncHeld();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule